// File: doc/BRIEF.md
# USB Interrupt Shadow and End-of-Interrupt Controller

This block sits next to a USB on-the-go core and keeps its own copy of every interrupt the core can raise. Single-cycle event pulses arrive from the core: transmit completions for endpoint 0 and four transmit endpoints, receive completions for receive endpoints 1 to 4, eight core-level USB events, and a drive-VBUS change event. Each pulse latches a bit in one 32-bit raw source word. Software reads and modifies that word through a simple 32-bit register bus. The bus offers separate write-one-to-set and write-one-to-clear aliases for both the source word and the enable mask, plus a read-only view of the source ANDed with the mask.

The CPU interrupt line `irq_o` comes from a three-state gate. In ST_ARMED the gate waits. When the masked source is nonzero it takes the transition ARM_TO_FIRE into ST_FIRE, where `irq_o` is high for exactly one cycle. It then always takes FIRE_TO_HELD into ST_HELD. In ST_HELD the line stays low, whatever arrives, until software writes any value to the end-of-interrupt address. That write causes HELD_TO_FIRE if masked events are still pending, and HELD_TO_ARM if nothing is pending. An end-of-interrupt write seen while in ST_FIRE is treated the same way: FIRE_TO_FIRE or FIRE_TO_ARM.

A typical handler does four things. It reads the masked view. It writes the value it read to the source-clear alias. It services the events. It writes the end-of-interrupt register. Software may also raise any source itself through the set alias, for example to force the drive-VBUS event.

Top module: `usb_irq_shadow`

## Requirements
- R1: After reset, every register reads zero at every decoded address and `irq_o` is low.
- R2: Each event pulse latches one source bit. The bits are: `tx_evt_i[i]` to bit i (bits 0..4); `rx_evt_i[i]` (receive endpoint i+1) to bit 9+i (bits 9..12); `core_evt_i[i]` to bit 16+i (bits 16..23); `vbus_drv_evt_i` to bit 24. Bits 5..8, 13..15 and 25..31 of the source and of the mask always read zero. With all inputs at their default values, the implemented bits form the mask 0x01FF1E1F.
- R3: Writing to source-set (0x24) sets the source bits written as one. Reads at 0x20, 0x24 and 0x28 all return the raw source.
- R4: Writing to source-clear (0x28) clears only the source bits written as one.
- R5: A write to 0x2C loads the mask. A write to 0x30 sets, and a write to 0x34 clears, only the mask bits written as one. Reads at 0x2C, 0x30 and 0x34 return the mask.
- R6: When an event pulse and a source-clear write hit the same bit in the same cycle, the bit ends up set.
- R7: A read at 0x38 returns source AND mask. Writes to 0x20 and 0x38 change no state.
- R8: In ST_ARMED, `irq_o` goes high for exactly one cycle. That cycle follows the first clock edge at which the registered masked source is nonzero. `irq_o` never rises while the masked source is zero.
- R9: Once `irq_o` has pulsed, it stays low until a write of any data to 0x3C. A read at 0x3C returns zero.
- R10: In the cycle after an end-of-interrupt write, `irq_o` is high if the masked source was nonzero. Otherwise the gate returns to ST_ARMED and fires on the next masked event, as in R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Register access in this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| tx_evt_i | input | N_TX | Transmit event pulses, endpoint 0 upward |
| rx_evt_i | input | N_RX | Receive event pulses, endpoint 1 upward |
| core_evt_i | input | N_CORE | Core-level USB event pulses |
| vbus_drv_evt_i | input | 1 | Drive-VBUS change event pulse |
| irq_o | output | 1 | One-cycle interrupt request to the CPU |

## Verification
Suppose the gate state is wrong, for example it is left in ST_ARMED after a pulse. Then a second event raised before the end-of-interrupt write produces an extra `irq_o` pulse one cycle after it is latched. The bench watches for that extra pulse. Suppose instead the gate is stuck in ST_HELD or misses the end-of-interrupt write. Then the pulse expected in the cycle right after the write never comes. A corrupted source or mask bit shows up as soon as 0x20, 0x2C or 0x38 is next read. The same corruption also shows as an `irq_o` pulse appearing or missing two edges after the stimulus.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;

    localparam int DATA_W = 32;

    // Register byte offsets (software-visible map)
    localparam logic [7:0] OFF_SRC      = 8'h20;
    localparam logic [7:0] OFF_SRC_SET  = 8'h24;
    localparam logic [7:0] OFF_SRC_CLR  = 8'h28;
    localparam logic [7:0] OFF_MASK     = 8'h2C;
    localparam logic [7:0] OFF_MASK_SET = 8'h30;
    localparam logic [7:0] OFF_MASK_CLR = 8'h34;
    localparam logic [7:0] OFF_MSRC     = 8'h38;
    localparam logic [7:0] OFF_EOI      = 8'h3C;

    typedef enum logic [1:0] {
        ST_ARMED = 2'd0,
        ST_FIRE  = 2'd1,
        ST_HELD  = 2'd2
    } eoi_state_e;

    typedef struct packed {
        logic src_set;
        logic src_clr;
        logic mask_ld;
        logic mask_set;
        logic mask_clr;
        logic eoi;
    } wr_strobe_t;

    function automatic logic [DATA_W-1:0] field_mask(input int lsb, input int n);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < DATA_W; i++) begin
            m[i] = (i >= lsb) && (i < lsb + n);
        end
        return m;
    endfunction

endpackage

// File: rtl/usb_irq_decode.sv
module usb_irq_decode
    import usb_irq_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic [DATA_W-1:0] mask_i,
    output wr_strobe_t        strobe_o,
    output logic [DATA_W-1:0] rdata_o
);

    logic wr_en;
    logic rd_en;

    assign wr_en = bus_sel_i && bus_wr_i;
    assign rd_en = bus_sel_i && !bus_wr_i;

    always_comb begin
        strobe_o          = '0;
        strobe_o.src_set  = wr_en && (bus_addr_i == ADDR_W'(OFF_SRC_SET));
        strobe_o.src_clr  = wr_en && (bus_addr_i == ADDR_W'(OFF_SRC_CLR));
        strobe_o.mask_ld  = wr_en && (bus_addr_i == ADDR_W'(OFF_MASK));
        strobe_o.mask_set = wr_en && (bus_addr_i == ADDR_W'(OFF_MASK_SET));
        strobe_o.mask_clr = wr_en && (bus_addr_i == ADDR_W'(OFF_MASK_CLR));
        strobe_o.eoi      = wr_en && (bus_addr_i == ADDR_W'(OFF_EOI));
    end

    // Read mux: source aliases return raw source, mask aliases return mask
    always_comb begin
        rdata_o = '0;
        if (rd_en) begin
            if (bus_addr_i == ADDR_W'(OFF_SRC) ||
                bus_addr_i == ADDR_W'(OFF_SRC_SET) ||
                bus_addr_i == ADDR_W'(OFF_SRC_CLR)) begin
                rdata_o = src_i;
            end else if (bus_addr_i == ADDR_W'(OFF_MASK) ||
                         bus_addr_i == ADDR_W'(OFF_MASK_SET) ||
                         bus_addr_i == ADDR_W'(OFF_MASK_CLR)) begin
                rdata_o = mask_i;
            end else if (bus_addr_i == ADDR_W'(OFF_MSRC)) begin
                rdata_o = src_i & mask_i;
            end
        end
    end

endmodule

// File: rtl/usb_irq_bitreg.sv
module usb_irq_bitreg
    import usb_irq_pkg::*;
#(
    parameter logic [DATA_W-1:0] VALID = '1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_en_i,
    input  logic [DATA_W-1:0] load_val_i,
    input  logic [DATA_W-1:0] set_i,
    input  logic [DATA_W-1:0] clr_i,
    input  logic [DATA_W-1:0] evt_i,
    output logic [DATA_W-1:0] q_o
);

    logic [DATA_W-1:0] base;
    logic [DATA_W-1:0] nxt;

    // Events are ORed in last, so they override clears and loads
    always_comb begin
        base = load_en_i ? load_val_i : ((q_o & ~clr_i) | set_i);
        nxt  = (base | evt_i) & VALID;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q_o <= '0;
        end else begin
            q_o <= nxt;
        end
    end

endmodule

// File: rtl/usb_irq_eoi_fsm.sv
module usb_irq_eoi_fsm
    import usb_irq_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pending_i,
    input  logic eoi_i,
    output logic irq_o
);

    eoi_state_e state_q;
    eoi_state_e state_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED: begin
                if (pending_i) state_d = ST_FIRE;        // ARM_TO_FIRE
            end
            ST_FIRE: begin
                if (eoi_i) state_d = pending_i ? ST_FIRE : ST_ARMED;
                else       state_d = ST_HELD;            // FIRE_TO_HELD
            end
            ST_HELD: begin
                if (eoi_i) state_d = pending_i ? ST_FIRE : ST_ARMED;
            end
            default: state_d = ST_ARMED;
        endcase
    end

    always_comb begin
        irq_o = (state_q == ST_FIRE);
    end

endmodule

// File: rtl/usb_irq_shadow.sv
module usb_irq_shadow
    import usb_irq_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int N_TX     = 5,
    parameter int N_RX     = 4,
    parameter int N_CORE   = 8,
    parameter int TX_LSB   = 0,
    parameter int RX_BASE  = 8,
    parameter int CORE_LSB = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    input  logic [N_TX-1:0]   tx_evt_i,
    input  logic [N_RX-1:0]   rx_evt_i,
    input  logic [N_CORE-1:0] core_evt_i,
    input  logic              vbus_drv_evt_i,
    output logic              irq_o
);

    localparam int RX_LSB   = RX_BASE + 1;
    localparam int VBUS_BIT = CORE_LSB + N_CORE;
    localparam logic [DATA_W-1:0] VALID =
        field_mask(TX_LSB, N_TX) | field_mask(RX_LSB, N_RX) |
        field_mask(CORE_LSB, N_CORE + 1);

    wr_strobe_t        strobe;
    logic [DATA_W-1:0] evt_vec;
    logic [DATA_W-1:0] src_q;
    logic [DATA_W-1:0] mask_q;
    logic [DATA_W-1:0] masked;

    always_comb begin
        evt_vec = '0;
        for (int i = 0; i < N_TX; i++)   evt_vec[TX_LSB + i]   = tx_evt_i[i];
        for (int i = 0; i < N_RX; i++)   evt_vec[RX_LSB + i]   = rx_evt_i[i];
        for (int i = 0; i < N_CORE; i++) evt_vec[CORE_LSB + i] = core_evt_i[i];
        evt_vec[VBUS_BIT] = vbus_drv_evt_i;
    end

    usb_irq_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_sel_i  (bus_sel_i),
        .bus_wr_i   (bus_wr_i),
        .bus_addr_i (bus_addr_i),
        .src_i      (src_q),
        .mask_i     (mask_q),
        .strobe_o   (strobe),
        .rdata_o    (bus_rdata_o)
    );

    usb_irq_bitreg #(.VALID(VALID)) u_src (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_en_i  (1'b0),
        .load_val_i ('0),
        .set_i      ({DATA_W{strobe.src_set}} & bus_wdata_i),
        .clr_i      ({DATA_W{strobe.src_clr}} & bus_wdata_i),
        .evt_i      (evt_vec),
        .q_o        (src_q)
    );

    usb_irq_bitreg #(.VALID(VALID)) u_mask (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_en_i  (strobe.mask_ld),
        .load_val_i (bus_wdata_i),
        .set_i      ({DATA_W{strobe.mask_set}} & bus_wdata_i),
        .clr_i      ({DATA_W{strobe.mask_clr}} & bus_wdata_i),
        .evt_i      ('0),
        .q_o        (mask_q)
    );

    assign masked = src_q & mask_q;

    usb_irq_eoi_fsm u_fsm (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .pending_i (|masked),
        .eoi_i     (strobe.eoi),
        .irq_o     (irq_o)
    );

endmodule

// File: rtl/usb_irq_shadow_chk.sv
module usb_irq_shadow_chk
    import usb_irq_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              bus_sel_i,
    input logic              bus_wr_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [31:0]       bus_rdata_o,
    input logic [31:0]       evt_vec,
    input logic [31:0]       src_q,
    input logic [31:0]       mask_q,
    input logic              irq_o
);

    logic eoi_wr;
    logic held_q;

    assign eoi_wr = bus_sel_i && bus_wr_i && (bus_addr_i == ADDR_W'(OFF_EOI));

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     held_q <= 1'b0;
        else if (eoi_wr) held_q <= 1'b0;
        else if (irq_o)  held_q <= 1'b1;
    end

    assert_event_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_vec != 0) |=> ((src_q & $past(evt_vec)) == $past(evt_vec)));

    assert_masked_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_sel_i && !bus_wr_i && bus_addr_i == ADDR_W'(OFF_MSRC))
        |-> (bus_rdata_o == (src_q & mask_q)));

    assert_raw_write_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_sel_i && bus_wr_i && bus_addr_i == ADDR_W'(OFF_SRC) && evt_vec == 0)
        |=> (src_q == $past(src_q)));

    assert_irq_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> $past((src_q & mask_q) != 0));

    assert_single_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_o && !eoi_wr) |=> !irq_o);

    assert_hold_until_eoi_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (held_q && !eoi_wr) |=> !irq_o);

    assert_eoi_refire_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eoi_wr && (src_q & mask_q) != 0) |=> irq_o);

endmodule

bind usb_irq_shadow usb_irq_shadow_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_sel_i   (bus_sel_i),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_rdata_o (bus_rdata_o),
    .evt_vec     (evt_vec),
    .src_q       (src_q),
    .mask_q      (mask_q),
    .irq_o       (irq_o)
);

// File: tb/usb_irq_shadow_test.sv
module usb_irq_shadow_test;

    localparam logic [31:0] VALID = 32'h01FF_1E1F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0;
    logic        wr = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [4:0]  tx = '0;
    logic [3:0]  rx = '0;
    logic [7:0]  core = '0;
    logic        vb = 1'b0;
    logic        irq;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    usb_irq_shadow uut (
        .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_wr_i(wr),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .tx_evt_i(tx), .rx_evt_i(rx), .core_evt_i(core),
        .vbus_drv_evt_i(vb), .irq_o(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = a;
        #1 d = rdata;
        sel = 1'b0;
    endtask

    task automatic read_check(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        bus_read(a, d);
        check(tag, d, exp);
    endtask

    task automatic pulse(input logic [4:0] t, input logic [3:0] r, input logic [7:0] c, input logic v);
        @(negedge clk);
        tx = t; rx = r; core = c; vb = v;
        @(negedge clk);
        tx = '0; rx = '0; core = '0; vb = 1'b0;
    endtask

    task automatic cleanup();
        bus_write(8'h28, 32'hFFFF_FFFF);
        bus_write(8'h34, 32'hFFFF_FFFF);
        bus_write(8'h3C, 32'h0);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 irq after reset", {31'b0, irq}, 32'h0);
        for (int i = 0; i < 8; i++) begin
            read_check("R1 reset read", 8'h20 + 8'(i * 4), 32'h0);
        end
    endtask

    task automatic t_layout();
        bus_write(8'h2C, 32'hFFFF_FFFF);
        read_check("R2 mask implemented bits", 8'h2C, VALID);
        pulse(5'b10101, 4'b0001, 8'h80, 1'b1);
        read_check("R2 event bit positions", 8'h20, 32'h0180_0215);
        pulse(5'b0, 4'b1000, 8'h01, 1'b0);
        read_check("R2 rx ep4 and core0", 8'h20, 32'h0181_1215);
        cleanup();
    endtask

    task automatic t_set_clear();
        bus_write(8'h24, 32'hFFFF_FFFF);
        read_check("R3 set raw read", 8'h20, VALID);
        read_check("R3 set alias read", 8'h24, VALID);
        read_check("R3 clear alias read", 8'h28, VALID);
        bus_write(8'h28, 32'h0100_0003);
        read_check("R4 clear written ones", 8'h20, VALID & ~32'h0100_0003);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R8 no irq with zero mask", {31'b0, irq}, 32'h0);
        end
        cleanup();
    endtask

    task automatic t_mask();
        bus_write(8'h2C, 32'h0000_00F0);
        read_check("R5 mask load", 8'h2C, 32'h0000_0010);
        bus_write(8'h30, 32'h0100_0001);
        read_check("R5 mask set", 8'h30, 32'h0100_0011);
        bus_write(8'h34, 32'h0000_0010);
        read_check("R5 mask clear", 8'h34, 32'h0100_0001);
        cleanup();
    endtask

    task automatic t_race();
        bus_write(8'h24, 32'h0000_0003);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = 8'h28; wdata = 32'h3; tx = 5'b00001;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0; tx = '0;
        read_check("R6 event beats clear", 8'h20, 32'h0000_0001);
        cleanup();
    endtask

    task automatic t_ignored();
        bus_write(8'h2C, 32'h0000_0204);
        bus_write(8'h24, 32'h0001_0204);
        read_check("R7 masked view", 8'h38, 32'h0000_0204);
        bus_write(8'h20, 32'h0);
        bus_write(8'h38, 32'hFFFF_FFFF);
        read_check("R7 raw write ignored", 8'h20, 32'h0001_0204);
        read_check("R7 mask untouched", 8'h2C, 32'h0000_0204);
        cleanup();
    endtask

    task automatic t_irq();
        bus_write(8'h2C, VALID);
        bus_write(8'h24, 32'h0000_0008);
        check("R8 irq not yet", {31'b0, irq}, 32'h0);
        @(negedge clk);
        check("R8 irq pulse", {31'b0, irq}, 32'h1);
        @(negedge clk);
        check("R8 irq one cycle", {31'b0, irq}, 32'h0);
        pulse(5'b0, 4'b1000, 8'h0, 1'b0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R9 held before eoi", {31'b0, irq}, 32'h0);
        end
        read_check("R9 eoi reads zero", 8'h3C, 32'h0);
        read_check("R7 pending masked", 8'h38, 32'h0000_1008);
        bus_write(8'h3C, 32'h1234_5678);
        check("R10 refire after eoi", {31'b0, irq}, 32'h1);
        @(negedge clk);
        check("R10 refire one cycle", {31'b0, irq}, 32'h0);
        bus_write(8'h28, VALID);
        bus_write(8'h3C, 32'h0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R10 no refire when idle", {31'b0, irq}, 32'h0);
        end
        pulse(5'b0, 4'b0, 8'h0, 1'b1);
        check("R8 armed not yet", {31'b0, irq}, 32'h0);
        @(negedge clk);
        check("R8 armed fires on vbus", {31'b0, irq}, 32'h1);
        cleanup();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_layout();
        t_set_clear();
        t_mask();
        t_race();
        t_ignored();
        t_irq();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule